// File: doc/BRIEF.md
# Severity-Based Error Pin Aggregator

This block gathers error messages from a set of PCI Express ports. Each port raises one-cycle strobes for three severities: correctable, non-fatal and fatal. Strobes from every port are merged per severity and gated by a per-severity enable. The merged result updates a root status register that separates the first occurrence of each class from later repeats. It also remembers whether the first uncorrectable message was fatal, and which uncorrectable kinds were seen.

Three active-low pins carry the severities to an external management controller. Each pin has its own two-bit mode. A pin can be off, can follow the recorded hardware status, or can follow a bit that software writes into a data register. An interrupt request goes to the message-interrupt logic while any enabled severity has status pending. Software reaches the configuration through a small write and read port.

Top module: `errpin_hub`

## Requirements
- R1: Severity enables sit at address 0: bit 0 correctable, bit 1 non-fatal, bit 2 fatal. A strobe on any port index is recorded only when its severity is enabled. A disabled severity leaves the status, the pins and the interrupt untouched.
- R2: Status bit 0 is set by an enabled correctable message when bit 0 is clear. Status bit 1 is set by an enabled correctable message that arrives while bit 0 is already set.
- R3: Status bit 2 is set by the first enabled non-fatal or fatal message. Status bit 3 is set by such a message that arrives while bit 2 is already set.
- R4: When bit 2 is newly set, status bit 4 is loaded with 1 if that message was fatal and with 0 otherwise. Non-fatal and fatal strobes in the same cycle give bit 4 = 1. Bit 5 marks that a non-fatal message was seen, and bit 6 that a fatal one was seen.
- R5: Status is at address 1 and is write-1-to-clear. In a cycle with both a clear and a strobe, the clear is applied first and the strobe is then judged against the cleared value.
- R6: Pin control is at address 2. Pin i uses bits [2i+1:2i]: 00 keeps the pin off, 01 follows hardware status, 10 follows software data, and 11 keeps the pin off.
- R7: In hardware mode, pin 0 is low while status bit 0 is set, pin 1 while bit 5 is set, and pin 2 while bit 6 is set. The pin changes in the cycle after the strobe edge.
- R8: In software mode, pin i is low while bit i of the data register at address 3 is set. Hardware mode ignores the data register.
- R9: After reset all registers read zero, every pin is high and the interrupt is low.
- R10: The interrupt is (bit0 & enable0) | (bit5 & enable1) | (bit6 & enable2).
- R11: Each register reads back what was written, through the read port, in its own low bits. Upper bits read zero.
- R12: Correctable and fatal strobes in the same cycle are both recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_strb | input | NPORTS | Correctable message strobe per port |
| nfat_strb | input | NPORTS | Non-fatal message strobe per port |
| fat_strb | input | NPORTS | Fatal message strobe per port |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 7 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 7 | Read data (combinational) |
| err_pin_n | output | 3 | Active-low severity pins, index = severity |
| irq | output | 1 | Interrupt request to message-interrupt logic |

## Verification
A write-1-to-clear of the status register and a new error strobe can land in the same cycle. The outcome hinges on the clear being applied before the first-or-multiple decision. The bench's vector table drives a clear of bit 0 together with a correctable strobe, and then a clear of bit 2 together with a non-fatal strobe. It expects the first-occurrence bits to be set again, the multiple bits to stay clear, and bit 4 to be reloaded from the new message. Simultaneous severities from different ports are judged the same way, against hand-computed status values.

// File: rtl/errpin_pkg.sv
package errpin_pkg;

    localparam int SEV_N  = 3;
    localparam int ST_W   = 7;
    localparam int PCTL_W = 2 * SEV_N;
    localparam int ADDR_W = 2;
    localparam int DATA_W = ST_W;

    localparam logic [ADDR_W-1:0] A_EN   = 2'd0;
    localparam logic [ADDR_W-1:0] A_ST   = 2'd1;
    localparam logic [ADDR_W-1:0] A_PCTL = 2'd2;
    localparam logic [ADDR_W-1:0] A_PDAT = 2'd3;

    typedef enum logic [1:0] {
        PM_OFF = 2'b00,
        PM_HW  = 2'b01,
        PM_SW  = 2'b10,
        PM_RSV = 2'b11
    } pin_mode_e;

    // index 0 correctable, 1 non-fatal, 2 fatal
    typedef struct packed {
        logic fat;
        logic nfat;
        logic corr;
    } sev_t;

    // bit 0 is co_first ... bit 6 is fat_seen
    typedef struct packed {
        logic fat_seen;
        logic nfat_seen;
        logic first_is_fat;
        logic uc_multi;
        logic uc_first;
        logic co_multi;
        logic co_first;
    } stat_t;

    function automatic logic pin_active(pin_mode_e m, logic hw, logic sw);
        case (m)
            PM_HW:   return hw;
            PM_SW:   return sw;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/errpin_merge.sv
module errpin_merge
    import errpin_pkg::*;
#(
    parameter int NPORTS = 11
) (
    input  logic [NPORTS-1:0] corr_strb,
    input  logic [NPORTS-1:0] nfat_strb,
    input  logic [NPORTS-1:0] fat_strb,
    input  sev_t              en,
    output sev_t              hit
);
    sev_t any;

    always_comb begin
        any = '0;
        for (int p = 0; p < NPORTS; p++) begin
            any.corr = any.corr | corr_strb[p];
            any.nfat = any.nfat | nfat_strb[p];
            any.fat  = any.fat  | fat_strb[p];
        end
        hit = any & en;
    end
endmodule

// File: rtl/errpin_status.sv
module errpin_status
    import errpin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  sev_t            hit,
    input  logic [ST_W-1:0] w1c,
    output stat_t           st
);
    stat_t st_q, cleared, nxt;

    always_comb begin
        cleared = stat_t'(st_q & ~w1c);
        nxt     = cleared;
        if (hit.corr) begin
            if (cleared.co_first) nxt.co_multi = 1'b1;
            else                  nxt.co_first = 1'b1;
        end
        if (hit.nfat || hit.fat) begin
            if (cleared.uc_first) begin
                nxt.uc_multi = 1'b1;
            end else begin
                nxt.uc_first     = 1'b1;
                nxt.first_is_fat = hit.fat;
            end
        end
        if (hit.nfat) nxt.nfat_seen = 1'b1;
        if (hit.fat)  nxt.fat_seen  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= nxt;
    end

    assign st = st_q;

    AST_MULTI_NEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.co_multi) |-> st_q.co_first); // R2
    AST_UC_MULTI_NEEDS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.uc_multi) |-> st_q.uc_first); // R3
    AST_FATAL_FIRST_SEEN: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.first_is_fat) |-> (st_q.fat_seen && st_q.uc_first)); // R4
    AST_CORR_RECORDED: assert property (@(posedge clk) disable iff (rst)
        hit.corr |=> st_q.co_first); // R5
endmodule

// File: rtl/errpin_drive.sv
module errpin_drive
    import errpin_pkg::*;
(
    input  stat_t             st,
    input  logic [PCTL_W-1:0] pctl,
    input  logic [SEV_N-1:0]  pdat,
    output logic [SEV_N-1:0]  pin_n
);
    logic [SEV_N-1:0] hw_src;
    assign hw_src = {st.fat_seen, st.nfat_seen, st.co_first};

    for (genvar i = 0; i < SEV_N; i++) begin : g_pin
        pin_mode_e mode;
        assign mode     = pin_mode_e'(pctl[2*i+1 -: 2]);
        assign pin_n[i] = ~pin_active(mode, hw_src[i], pdat[i]);
    end
endmodule

// File: rtl/errpin_hub.sv
module errpin_hub
    import errpin_pkg::*;
#(
    parameter int NPORTS = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPORTS-1:0] corr_strb,
    input  logic [NPORTS-1:0] nfat_strb,
    input  logic [NPORTS-1:0] fat_strb,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [6:0]        wr_data,
    input  logic [1:0]        rd_addr,
    output logic [6:0]        rd_data,
    output logic [2:0]        err_pin_n,
    output logic              irq
);
    sev_t              en_q;
    logic [PCTL_W-1:0] pctl_q;
    logic [SEV_N-1:0]  pdat_q;
    sev_t              hit;
    stat_t             st;
    logic [ST_W-1:0]   w1c;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pctl_q <= '0;
            pdat_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_EN:    en_q   <= sev_t'(wr_data[SEV_N-1:0]);
                A_PCTL:  pctl_q <= wr_data[PCTL_W-1:0];
                A_PDAT:  pdat_q <= wr_data[SEV_N-1:0];
                default: ;
            endcase
        end
    end

    assign w1c = (wr_en && wr_addr == A_ST) ? wr_data : '0;

    errpin_merge #(.NPORTS(NPORTS)) u_merge (
        .corr_strb(corr_strb), .nfat_strb(nfat_strb), .fat_strb(fat_strb),
        .en(en_q), .hit(hit)
    );

    errpin_status u_status (
        .clk(clk), .rst(rst), .hit(hit), .w1c(w1c), .st(st)
    );

    errpin_drive u_drive (
        .st(st), .pctl(pctl_q), .pdat(pdat_q), .pin_n(err_pin_n)
    );

    assign irq = (st.co_first & en_q.corr) | (st.nfat_seen & en_q.nfat)
               | (st.fat_seen & en_q.fat);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_EN:    rd_data[SEV_N-1:0]  = en_q;
            A_ST:    rd_data             = st;
            A_PCTL:  rd_data[PCTL_W-1:0] = pctl_q;
            default: rd_data[SEV_N-1:0]  = pdat_q;
        endcase
    end

    AST_PINS_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (err_pin_n == 3'b111 && !irq)); // R9
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st != '0)); // R10
    AST_HW_PIN_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (!err_pin_n[0] && pctl_q[1:0] == 2'b01) |-> st.co_first); // R7
endmodule

// File: tb/tb_errpin_hub.sv
module tb_errpin_hub;
    localparam int NP = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] corr_strb = '0, nfat_strb = '0, fat_strb = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0, rd_addr = '0;
    logic [6:0]    wr_data = '0;
    logic [6:0]    rd_data;
    logic [2:0]    err_pin_n;
    logic          irq;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    errpin_hub #(.NPORTS(NP)) dut (
        .clk(clk), .rst(rst), .corr_strb(corr_strb), .nfat_strb(nfat_strb),
        .fat_strb(fat_strb), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .err_pin_n(err_pin_n), .irq(irq)
    );

    // {port[3:0], sev{fat,nfat,corr}[2:0], clear[6:0], expected status[6:0]}
    localparam logic [20:0] VEC [10] = '{
        {4'd0,  3'b001, 7'h00, 7'h01},  // R2 first correctable
        {4'd10, 3'b001, 7'h00, 7'h03},  // R2 multiple correctable
        {4'd5,  3'b010, 7'h00, 7'h27},  // R3 first uncorrectable, non-fatal
        {4'd3,  3'b100, 7'h00, 7'h6F},  // R3 multiple uncorrectable
        {4'd0,  3'b000, 7'h7F, 7'h00},  // R5 clear all
        {4'd7,  3'b101, 7'h00, 7'h55},  // R12 corr + fatal together
        {4'd1,  3'b001, 7'h01, 7'h55},  // R5 clear bit0 + strobe: first again
        {4'd2,  3'b110, 7'h7F, 7'h74},  // R4 nf + fatal: fatal decides bit 4
        {4'd9,  3'b010, 7'h04, 7'h64},  // R5/R4 clear bit2 + nf: bit 4 reloaded 0
        {4'd0,  3'b000, 7'h7F, 7'h00}   // R5 clear all
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [6:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [6:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic strobe(int port, logic [2:0] sev, logic [6:0] clr);
        @(negedge clk);
        corr_strb[port] = sev[0];
        nfat_strb[port] = sev[1];
        fat_strb[port]  = sev[2];
        if (clr != 0) begin
            wr_en = 1'b1; wr_addr = 2'd1; wr_data = clr;
        end
        @(negedge clk);
        corr_strb = '0; nfat_strb = '0; fat_strb = '0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [6:0] v;
        repeat (3) @(negedge clk);
        chk("R9 pins in reset", err_pin_n, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 pins after reset", err_pin_n, 3'b111);
        chk("R9 irq after reset", irq, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            chk("R9 register zero after reset", v, 0);
        end

        // R1: all severities disabled, strobes ignored
        strobe(6, 3'b111, 7'h00);
        rd(2'd1, v);
        chk("R1 disabled status", v, 0);
        chk("R1 disabled irq", irq, 0);

        wr(2'd0, 7'h07);
        rd(2'd0, v);
        chk("R11 enable readback", v, 7'h07);

        foreach (VEC[i]) begin
            strobe(int'(VEC[i][20:17]), VEC[i][16:14], VEC[i][13:7]);
            rd(2'd1, v);
            chk($sformatf("R2/R3/R4/R5/R12 vector %0d", i), v, VEC[i][6:0]);
        end

        // R6/R7 hardware mode on all pins: control 01 01 01
        wr(2'd2, 7'h15);
        rd(2'd2, v);
        chk("R11 pin control readback", v, 7'h15);
        chk("R6 hw mode idle pins", err_pin_n, 3'b111);
        strobe(4, 3'b001, 7'h00);
        chk("R7 corr drives pin0", err_pin_n, 3'b110);
        chk("R10 irq on correctable", irq, 1);
        strobe(0, 3'b100, 7'h00);
        chk("R7 fatal drives pin2", err_pin_n, 3'b010);
        wr(2'd0, 7'h02);
        chk("R10 irq masked by enables", irq, 0);
        wr(2'd0, 7'h07);
        wr(2'd1, 7'h7F);
        chk("R5/R7 pins release after clear", err_pin_n, 3'b111);
        chk("R10 irq low after clear", irq, 0);

        // R8: hardware mode ignores software data
        wr(2'd3, 7'h07);
        chk("R8 hw mode ignores data", err_pin_n, 3'b111);
        wr(2'd3, 7'h05);
        rd(2'd3, v);
        chk("R11 data readback", v, 7'h05);
        wr(2'd2, 7'h2A);
        chk("R8 sw mode follows data", err_pin_n, 3'b010);
        wr(2'd2, 7'h2B);
        chk("R6 mode 11 keeps pin0 off", err_pin_n, 3'b011);
        wr(2'd2, 7'h00);
        chk("R6 mode 00 keeps pins off", err_pin_n, 3'b111);

        finish_run();
    end
endmodule